// File: doc/BRIEF.md
# Serial Tag-Memory Command Controller

This block is a serial slave that sits behind a four-wire link: an active-low select, a serial clock, a data input and a data output with its own output enable. Each frame carries an 8-bit opcode and then a 24-bit dummy field. A command is not carried out while it is being shifted in. It is held until the select line is released, and it takes effect only after a short run of clocks that follow the release.

A write-enable latch guards the commands that modify the tag memory. The block does not contain the memory itself. Programming, erasing and the status operation are passed on as one-cycle request pulses, and a read of the tag memory is passed on the same way. The read-identification command returns a 32-bit code, set by a parameter, straight after the dummy field. At all other times the data output is undriven, which the block shows by holding its output enable low.

Top module: `tag_cmd_slave`

## Requirements
- R1: The serial input is sampled on the rising edge of `sclk` while `cs_n` is low, most significant opcode bit first. A frame is 8 opcode bits followed by 24 dummy bits.
- R2: Opcode 0xAC sets the write-enable latch.
- R3: Opcode 0x78 clears the write-enable latch, and the latch then stays clear until a new 0xAC frame is committed.
- R4: When `cs_n` rises before 32 bits of the frame have been sampled, the frame is discarded and has no effect.
- R5: Rising edges with `cs_n` low after the 32nd bit do not change how the frame is decoded or what it does.
- R6: A valid frame commits on the third rising edge of `sclk` after the edge that first sees `cs_n` high, counting that edge as the first. Its request pulse is high for exactly the cycle after the commit edge. If `cs_n` falls before the third edge, the frame is dropped.
- R7: Program-tag (0x9C), erase-tag (0x8E) and status (0xB4) raise `prog_req`, `erase_req` and `stat_req` respectively, each as a single-cycle pulse. They do so only while the write-enable latch is set, and otherwise they do nothing.
- R8: Read-tag (0x8A) raises `rdtag_req` whatever the state of the latch. Read-ID (0xE0) returns its code whatever the state of the latch.
- R9: For read-ID (0xE0), `so_oe` goes high on the falling edge after the 32nd sampled bit. `so` then presents the 32-bit ID word most significant bit first, changing on falling edges. `so_oe` is low before the word, after its 32 bits, and whenever `cs_n` is high.
- R10: An unknown opcode raises no request, drives no output and leaves the latch unchanged.
- R11: After reset the latch is clear, `so_oe` is low and all request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Select, active low |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| prog_req | output | 1 | Program-tag request pulse |
| erase_req | output | 1 | Erase-tag request pulse |
| stat_req | output | 1 | Status request pulse |
| rdtag_req | output | 1 | Read-tag request pulse |

## Verification
The assertions take two things for granted about the inputs. First, `sclk` keeps running after `cs_n` is released, so that the run of post-release edges can happen. Second, `cs_n` changes only between clock edges, never on one. The bench keeps to both. It runs a free clock and drives `si` and `cs_n` one nanosecond after each rising edge, so the rising edge always samples stable inputs and the falling-edge output logic already sees the new select level. The check on the post-release window is written for the default count of three edges.

// File: rtl/tag_cmd_slave.sv
module tag_cmd_slave #(
  parameter logic [31:0] ID_WORD   = 32'h1A2B_3C4D,
  parameter logic [7:0]  OP_WREN   = 8'hAC,
  parameter logic [7:0]  OP_WRDI   = 8'h78,
  parameter logic [7:0]  OP_RDID   = 8'hE0,
  parameter logic [7:0]  OP_PROG   = 8'h9C,
  parameter logic [7:0]  OP_ERASE  = 8'h8E,
  parameter logic [7:0]  OP_STAT   = 8'hB4,
  parameter logic [7:0]  OP_RDTAG  = 8'h8A,
  parameter int          DUMMY_BITS = 24,
  parameter int          POST_CLKS  = 3
) (
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic si,
  output logic so,
  output logic so_oe,
  output logic prog_req,
  output logic erase_req,
  output logic stat_req,
  output logic rdtag_req
);
  localparam int HDR   = 8;
  localparam int IDW   = 32;
  localparam int FRAME = HDR + DUMMY_BITS;
  localparam int LAST  = FRAME + IDW;
  localparam int CW    = $clog2(LAST + 1);
  localparam int PW    = $clog2(POST_CLKS + 1);
  localparam logic [CW-1:0] HDR_C   = CW'(HDR);
  localparam logic [CW-1:0] FRAME_C = CW'(FRAME);
  localparam logic [CW-1:0] LAST_C  = CW'(LAST);
  localparam logic [PW-1:0] FIN_C   = PW'(POST_CLKS - 1);

  logic [CW-1:0]  cnt;
  logic [HDR-1:0] op, arm_op;
  logic [PW-1:0]  post;
  logic           cs_d, armed, wel;
  logic           so_q, oe_q;
  logic [IDW-1:0] sh;
  logic           known;

  assign known = (op == OP_WREN) || (op == OP_WRDI) || (op == OP_PROG) ||
                 (op == OP_ERASE) || (op == OP_STAT) || (op == OP_RDTAG);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; op <= '0; arm_op <= '0; post <= '0;
      cs_d <= 1'b1; armed <= 1'b0; wel <= 1'b0;
      prog_req <= 1'b0; erase_req <= 1'b0; stat_req <= 1'b0; rdtag_req <= 1'b0;
    end else begin
      cs_d <= cs_n;
      prog_req <= 1'b0; erase_req <= 1'b0; stat_req <= 1'b0; rdtag_req <= 1'b0;
      if (!cs_n) begin
        armed <= 1'b0;
        post  <= '0;
        if (cnt != LAST_C) cnt <= cnt + 1'b1;
        if (cnt < HDR_C) op <= {op[HDR-2:0], si};
      end else begin
        cnt <= '0;
        if (!cs_d) begin
          armed  <= (cnt >= FRAME_C) && known;
          arm_op <= op;
          post   <= PW'(1);
        end else if (armed) begin
          if (post == FIN_C) begin
            armed <= 1'b0;
            if (arm_op == OP_WREN) wel <= 1'b1;
            if (arm_op == OP_WRDI) wel <= 1'b0;
            prog_req  <= wel && (arm_op == OP_PROG);
            erase_req <= wel && (arm_op == OP_ERASE);
            stat_req  <= wel && (arm_op == OP_STAT);
            rdtag_req <= (arm_op == OP_RDTAG);
          end else begin
            post <= post + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      so_q <= 1'b0; oe_q <= 1'b0; sh <= '0;
    end else begin
      oe_q <= !cs_n && (op == OP_RDID) && (cnt >= FRAME_C) && (cnt < LAST_C);
      if (cnt == FRAME_C) begin
        so_q <= ID_WORD[IDW-1];
        sh   <= ID_WORD << 1;
      end else begin
        so_q <= sh[IDW-1];
        sh   <= sh << 1;
      end
    end
  end

  assign so    = so_q;
  assign so_oe = oe_q & ~cs_n;
endmodule

// File: rtl/tag_cmd_slave_chk.sv
module tag_cmd_slave_chk (
  input logic sclk,
  input logic rst_n,
  input logic cs_n,
  input logic prog_req,
  input logic erase_req,
  input logic stat_req,
  input logic rdtag_req,
  input logic wel
);
  logic any_req;
  assign any_req = prog_req | erase_req | stat_req | rdtag_req;

  a_r7_one_req: assert property (@(posedge sclk) disable iff (!rst_n)
    $onehot0({prog_req, erase_req, stat_req, rdtag_req}));

  a_r6_single_pulse: assert property (@(posedge sclk) disable iff (!rst_n)
    any_req |=> !any_req);

  // R6: window written for the default of three post-release edges
  a_r6_third_clock: assert property (@(posedge sclk) disable iff (!rst_n)
    any_req |-> ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3) && !$past(cs_n, 4)));

  a_r7_latch_gate: assert property (@(posedge sclk) disable iff (!rst_n)
    (prog_req | erase_req | stat_req) |-> $past(wel));

  a_r11_quiet: assert property (@(posedge sclk) disable iff (!rst_n)
    $rose(rst_n) |-> !any_req);
endmodule

bind tag_cmd_slave tag_cmd_slave_chk u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n),
  .prog_req(prog_req), .erase_req(erase_req), .stat_req(stat_req),
  .rdtag_req(rdtag_req), .wel(wel)
);

// File: tb/sim_tag_cmd_slave.sv
`timescale 1ns/100ps
module sim_tag_cmd_slave;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, prog_req, erase_req, stat_req, rdtag_req;
  int checks = 0, fails = 0;
  int exp_q[$];
  bit done = 0;
  localparam logic [31:0] IDV = 32'h1A2B_3C4D;

  always #2.5 clk = ~clk;

  tag_cmd_slave u0 (.rst_n(rst_n), .sclk(clk), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .prog_req(prog_req), .erase_req(erase_req), .stat_req(stat_req), .rdtag_req(rdtag_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every request pulse must match the next expected item (R6, R7, R8, R10)
  always @(negedge clk) if (rst_n && !done) begin
    int code;
    code = prog_req ? 1 : erase_req ? 2 : stat_req ? 3 : rdtag_req ? 4 : 0;
    if (code != 0) begin
      if (exp_q.size() == 0) chk("R7/R10 unexpected pulse", code, 0);
      else chk("R7/R8 pulse", code, exp_q.pop_front());
    end
  end

  task automatic frame(input logic [7:0] op, input int nbits, input int post, input int exp_code);
    logic [31:0] word = '0;
    if (exp_code != 0) exp_q.push_back(exp_code);
    for (int i = 0; i < nbits; i++) begin
      cs_n = 1'b0;
      si = (i < 8) ? op[7-i] : 1'b0;
      @(posedge clk); #1;
      if (op == 8'hE0) begin
        chk("R9 oe", so_oe, (i >= 32 && i < 64));
        if (i >= 32 && i < 64) word[63-i] = so;
      end
    end
    cs_n = 1'b1; si = 1'b0;
    if (op == 8'hE0 && nbits >= 64) chk("R9 id word", word, IDV);
    for (int i = 0; i < post; i++) begin
      @(posedge clk); #1;
      if (op == 8'hE0) chk("R9 oe after release", so_oe, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 oe", so_oe, 0);
    chk("R11 reqs", {prog_req, erase_req, stat_req, rdtag_req}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    frame(8'h9C, 32, 4, 0);          // R7: latch clear -> no program
    frame(8'hAC, 32, 3, 0);          // R2, R1
    frame(8'h9C, 32, 4, 1);          // R7
    frame(8'h8E, 32, 4, 2);          // R7
    frame(8'hB4, 32, 4, 3);          // R7
    frame(8'h78, 20, 4, 0);          // R4: short frame dropped
    frame(8'h9C, 32, 4, 1);          // R4: latch still set
    frame(8'h78, 32, 2, 0);          // R6: too few post clocks
    frame(8'h8E, 32, 4, 2);          // R6: disable was dropped
    frame(8'h78, 40, 3, 0);          // R5, R3: extra clocks ignored
    frame(8'h9C, 32, 4, 0);          // R3: latch clear
    frame(8'h8A, 32, 4, 4);          // R8: read-tag while disabled
    frame(8'hE0, 64, 3, 0);          // R8, R9
    frame(8'h55, 32, 4, 0);          // R10
    frame(8'hB4, 32, 4, 0);          // R10: latch not set by unknown
    frame(8'hAC, 32, 3, 0);
    frame(8'h00, 32, 4, 0);          // R10: unknown keeps latch set
    frame(8'hB4, 32, 4, 3);
    frame(8'hE0, 70, 3, 0);          // R9: oe drops after 32 ID bits
    frame(8'hE0, 40, 3, 0);          // R9: early release stops drive
    repeat (6) @(posedge clk);
    #1;
    chk("R6 all pulses seen", exp_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule